// File: doc/BRIEF.md
# Interrupt Priority Level Gate

This block decides, once per clock, whether any pending interrupt may be taken by the core. Each maskable source raises a request line and supplies a 2-bit priority. A separate non-maskable request is always ranked at priority 3. A candidate qualifies only when its priority is strictly greater than the current 2-bit interrupt level. That level is the pair of mask bits kept in the upper two bits (7:6) of the status register, with the upper bit on `cur_level[1]`.

Among the qualifying candidates, the highest priority wins. A tie goes to the lowest vector number. The winner is reported through a one-cycle take strobe, together with its vector number and the level that must be written back to the status register. The level written back is the accepted priority, so that later requests at that level or below stay blocked until software lowers it.

After a take, the gate skips one evaluation cycle. This leaves the core a cycle to write the new level back, so a single event is never taken twice. Vector fetch, context stacking and the priority registers themselves belong to neighbouring logic. Take, vector and level are plain control pins, with no handshake.

Top module: `irq_level_gate`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `take_strobe`, `take_vector` and `take_level` are all zero.
- R2: A maskable source i is a candidate only if `irq_req[i]` is 1 and its priority `irq_prio[2i+1:2i]` is strictly greater than `cur_level`. A priority-0 source is never taken.
- R3: The non-maskable request is compared as priority 3. It is taken whenever `cur_level` is below 3, and it is blocked when `cur_level` is 3.
- R4: When several candidates exist, the one with the highest priority is taken.
- R5: Among candidates of equal priority, the lowest vector wins. The non-maskable request beats any maskable priority-3 source.
- R6: The vector reported is `NMI_VECTOR` (default 0) for the non-maskable request and `SRC_BASE + i` (default 1 + i) for source i. Vectors lie in 0..127.
- R7: On a take, `take_level` equals the accepted priority (3 for the non-maskable request), which is strictly greater than the `cur_level` it was compared against.
- R8: Inputs sampled at one clock edge produce `take_strobe` after that edge. The strobe is high for exactly one cycle. The edge right after a take never yields another take.
- R9: `take_vector` and `take_level` change only together with a take and hold their values between takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | N_SRC | Maskable request lines, one per source |
| irq_prio | input | 2*N_SRC | Priorities, source i at bits 2i+1:2i |
| nmi_req | input | 1 | Non-maskable request (priority 3) |
| cur_level | input | 2 | Current interrupt level from the status register, bit 1 = upper mask bit |
| take_strobe | output | 1 | One-cycle pulse: an interrupt is taken |
| take_vector | output | VEC_W | Vector number of the taken interrupt |
| take_level | output | 2 | Level to write back to the status register |

## Verification
The hardest state to reach is a request that stays pending across the take while the level is not written back. Here only the skipped evaluation cycle keeps the same event from being taken twice. The bench reaches it by holding a request and a fixed `cur_level` for many cycles, which forces the take/skip alternation. It also drives the non-maskable request at level 3, and ties of equal priority with and without the non-maskable request. A random phase then moves `cur_level` to the last written-back level, as a core would.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  typedef logic [1:0] level_t;

  localparam level_t LVL_TOP = 2'd3;

  // strict comparison used everywhere a candidate is qualified
  function automatic logic outranks(input level_t prio, input level_t lvl);
    return prio > lvl;
  endfunction
endpackage

// File: rtl/irq_qualify.sv
module irq_qualify
  import irq_gate_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic [N_SRC-1:0]   req,
  input  logic [2*N_SRC-1:0] prio,
  input  logic               nmi,
  input  level_t             level,
  output logic [N_SRC-1:0]   qual,
  output logic               nmi_ok
);
  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_src
      assign qual[g] = req[g] && outranks(prio[2*g +: 2], level);
    end
  endgenerate

  assign nmi_ok = nmi && outranks(LVL_TOP, level);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_gate_pkg::*;
#(
  parameter int N_SRC      = 8,
  parameter int VEC_W      = 7,
  parameter int NMI_VECTOR = 0,
  parameter int SRC_BASE   = 1
) (
  input  logic [N_SRC-1:0]   qual,
  input  logic [2*N_SRC-1:0] prio,
  input  logic               nmi_ok,
  output logic               win,
  output logic [VEC_W-1:0]   win_vec,
  output level_t             win_lvl
);
  localparam logic [VEC_W-1:0] NMI_V  = VEC_W'(NMI_VECTOR);
  localparam logic [VEC_W-1:0] BASE_V = VEC_W'(SRC_BASE);

  // ascending scan; strict ">" keeps the earliest (lowest vector) on ties
  always_comb begin
    win     = nmi_ok;
    win_vec = nmi_ok ? NMI_V : '0;
    win_lvl = nmi_ok ? LVL_TOP : 2'd0;
    for (int i = 0; i < N_SRC; i++) begin
      if (qual[i] && (!win || (prio[2*i +: 2] > win_lvl))) begin
        win     = 1'b1;
        win_vec = BASE_V + VEC_W'(i);
        win_lvl = prio[2*i +: 2];
      end
    end
  end
endmodule

// File: rtl/irq_level_gate.sv
module irq_level_gate
  import irq_gate_pkg::*;
#(
  parameter int N_SRC      = 8,
  parameter int VEC_W      = 7,
  parameter int NMI_VECTOR = 0,
  parameter int SRC_BASE   = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_SRC-1:0]     irq_req,
  input  logic [2*N_SRC-1:0]   irq_prio,
  input  logic                 nmi_req,
  input  logic [1:0]           cur_level,
  output logic                 take_strobe,
  output logic [VEC_W-1:0]     take_vector,
  output logic [1:0]           take_level
);
  logic [N_SRC-1:0] qual;
  logic             nmi_ok;
  logic             win;
  logic [VEC_W-1:0] win_vec;
  level_t           win_lvl;

  irq_qualify #(.N_SRC(N_SRC)) u_qual (
    .req    (irq_req),
    .prio   (irq_prio),
    .nmi    (nmi_req),
    .level  (cur_level),
    .qual   (qual),
    .nmi_ok (nmi_ok)
  );

  irq_arbiter #(
    .N_SRC      (N_SRC),
    .VEC_W      (VEC_W),
    .NMI_VECTOR (NMI_VECTOR),
    .SRC_BASE   (SRC_BASE)
  ) u_arb (
    .qual    (qual),
    .prio    (irq_prio),
    .nmi_ok  (nmi_ok),
    .win     (win),
    .win_vec (win_vec),
    .win_lvl (win_lvl)
  );

  // a take blocks the following evaluation so the level can be written back
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_strobe <= 1'b0;
      take_vector <= '0;
      take_level  <= 2'd0;
    end else begin
      take_strobe <= win && !take_strobe;
      if (win && !take_strobe) begin
        take_vector <= win_vec;
        take_level  <= win_lvl;
      end
    end
  end

  // R8
  take_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_strobe |=> !take_strobe);

  // R7
  level_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_strobe |-> (take_level > $past(cur_level)));

  // R2
  no_zero_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_strobe |-> (take_level != 2'd0));

  // R9
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_strobe |-> ($stable(take_vector) && $stable(take_level)));

  // R3
  nmi_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && cur_level != 2'd3 && !take_strobe) |=>
      (take_strobe && take_vector == VEC_W'(NMI_VECTOR) && take_level == 2'd3));
endmodule

// File: tb/tb_irq_level_gate.sv
module tb_irq_level_gate;
  localparam int N     = 8;
  localparam int VW    = 7;
  localparam int NMIV  = 0;
  localparam int BASE  = 1;
  localparam int CLK_PERIOD = 10;

  logic            clk = 0;
  logic            rst_n = 0;
  logic [N-1:0]    req = '0;
  logic [2*N-1:0]  pr = '0;
  logic            nmi = 0;
  logic [1:0]      lvl = 0;
  logic            t_stb;
  logic [VW-1:0]   t_vec;
  logic [1:0]      t_lvl;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string tag = "R1";

  int e_acc = 0, e_vec = 0, e_lvl = 0;

  irq_level_gate #(.N_SRC(N), .VEC_W(VW), .NMI_VECTOR(NMIV), .SRC_BASE(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .irq_req(req), .irq_prio(pr), .nmi_req(nmi),
    .cur_level(lvl), .take_strobe(t_stb), .take_vector(t_vec), .take_level(t_lvl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference, updated on each edge
  always @(posedge clk) begin
    if (!rst_n) begin
      e_acc = 0; e_vec = 0; e_lvl = 0;
    end else begin
      int bp, bv;
      bp = -1; bv = 0;
      if (nmi && 3 > lvl) begin bp = 3; bv = NMIV; end
      for (int i = 0; i < N; i++) begin
        int p;
        p = pr[2*i +: 2];
        if (req[i] && p > lvl && p > bp) begin bp = p; bv = BASE + i; end
      end
      if (bp >= 0 && e_acc == 0) begin
        e_acc = 1; e_vec = bv; e_lvl = bp;
      end else e_acc = 0;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    compared++;
    if (t_stb !== e_acc[0] || t_vec !== e_vec[VW-1:0] || t_lvl !== e_lvl[1:0]) begin
      mismatched++;
      $display("FAIL %s: take=%0b/%0b vector=%0d/%0d level=%0d/%0d (actual/expected)",
               tag, t_stb, e_acc, t_vec, e_vec, t_lvl, e_lvl);
    end
  end

  task automatic clear_src();
    req = '0; pr = '0; nmi = 0;
  endtask

  task automatic set_src(input int i, input logic [1:0] p);
    req[i] = 1'b1; pr[2*i +: 2] = p;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      mismatched++;
      $display("FAIL watchdog: cycles=%0d expected<=50000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R1: reset state, requests pending during reset
    tag = "R1";
    set_src(0, 2'd3); nmi = 1;
    wait_cycles(3);
    clear_src();
    rst_n = 1;
    wait_cycles(2);

    // R2: equal priority is blocked, higher passes; priority 0 never taken
    tag = "R2";
    lvl = 2; set_src(3, 2'd2); wait_cycles(4);
    lvl = 1; wait_cycles(3);
    clear_src(); lvl = 0; set_src(4, 2'd0); wait_cycles(4);

    // R3: non-maskable blocked at level 3, taken below
    tag = "R3";
    clear_src(); nmi = 1; lvl = 3; wait_cycles(4);
    lvl = 2; wait_cycles(3);
    lvl = 0; wait_cycles(3);

    // R4: highest priority wins
    tag = "R4";
    clear_src(); lvl = 0;
    set_src(1, 2'd1); set_src(5, 2'd3); set_src(6, 2'd2); wait_cycles(3);
    lvl = 2'd3; wait_cycles(2);
    lvl = 2'd1; clear_src(); set_src(0, 2'd1); set_src(7, 2'd2); wait_cycles(3);

    // R5: ties to lowest vector; non-maskable beats priority-3 sources
    tag = "R5";
    clear_src(); lvl = 0; set_src(6, 2'd3); set_src(2, 2'd3); wait_cycles(3);
    nmi = 1; wait_cycles(3);
    clear_src(); set_src(7, 2'd1); set_src(4, 2'd1); set_src(5, 2'd1); wait_cycles(3);

    // R6: vector numbering at the top end
    tag = "R6";
    clear_src(); set_src(N-1, 2'd2); wait_cycles(3);

    // R7: level written back equals accepted priority
    tag = "R7";
    clear_src(); lvl = 1; set_src(3, 2'd2); wait_cycles(2);
    lvl = 2; wait_cycles(3);

    // R8: held request, level not written back: take/skip alternation
    tag = "R8";
    clear_src(); lvl = 0; set_src(2, 2'd1); wait_cycles(12);

    // R9: outputs hold once nothing qualifies
    tag = "R9";
    clear_src(); wait_cycles(6);
    set_src(1, 2'd1); lvl = 1; wait_cycles(4);

    // R4: random traffic, level follows the written-back value
    tag = "R4";
    for (int k = 0; k < 3000; k++) begin
      req = N'($urandom); pr = (2*N)'($urandom);
      nmi = ($urandom_range(0, 15) == 0);
      if (t_stb) lvl = t_lvl;
      else if ($urandom_range(0, 7) == 0) lvl = 2'($urandom);
      @(negedge clk);
    end

    clear_src();
    wait_cycles(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule